// File: doc/BRIEF.md
# Shadow/Host Output Buffer Controller

This block moves one message buffer at a time out of a message RAM toward the CPU. It owns a storage area split into two equal halves. One half is the shadow, which the block fills from the RAM in the background. The other half is the host half, which the CPU reads through a word-indexed read port. Software programs a section-select register to choose the header section, the data section, or both. It then writes a command register that holds the target buffer number, a fetch command and a swap command.

Every message buffer takes `HDR_WORDS + DATA_WORDS` consecutive RAM words. The header comes first and the data section follows it. A fetch reads the selected words in ascending address order, one per cycle, from a RAM with one cycle of read latency. A busy flag stays set for the whole copy. A swap exchanges the roles of the two halves. Each half carries its own tag: the buffer number and the section selects that it was last filled with. After a swap, the host-side read-only fields therefore describe whatever the host can now read.

Top module: `obuf_ctrl`

## Requirements
- R1: The command register (cpu_addr=1) holds the target buffer number at bits [6:0] (read/write), the swap command at bit 8, the fetch command at bit 9, busy at bit 15 (read-only), and the host buffer number at bits [22:16] (read-only). The select register (cpu_addr=0) holds header-select at bit 0 and data-select at bit 1 (read/write), and host header flag at bit 16 and host data flag at bit 17 (read-only). All other bits read 0.
- R2: A fetch of buffer N copies each selected word from RAM address N*(HDR_WORDS+DATA_WORDS)+offset into the same offset of the shadow half. Header offsets are 0..HDR_WORDS-1 and data offsets follow them. Words are requested in ascending address order, one per cycle.
- R3: A fetch that moves n words keeps busy high for exactly n+1 cycles, so busy drops on the cycle after the last shadow write. A fetch with neither section selected moves nothing and never raises busy.
- R4: A swap exchanges the shadow and host halves. The host number field, the host section flags and the host read port then reflect the half that was the shadow.
- R5: A section that a fetch does not select keeps its previous contents in that half.
- R6: When one command write carries both swap and fetch, the swap takes effect first and the fetch fills the new shadow half, which was the host half before the write.
- R7: Fetch and swap commands written while busy is set are dropped. The target number in the same write is still stored.
- R8: The fetch and swap bits always read back as 0.
- R9: After reset, both registers read 0, busy is low, and both halves carry buffer number 0 with no sections selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 1 | Register select: 0 section select, 1 command |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational) |
| ram_en | output | 1 | Message RAM read enable |
| ram_addr | output | AW | Message RAM word address |
| ram_rdata | input | WORD_W | RAM data, valid one cycle after ram_en |
| host_idx | input | OFF_W | Word offset within the host half |
| host_rdata | output | WORD_W | Host half word at host_idx |

## Verification
The bench sweeps every buffer number and cycles through all four section-select patterns. After each fetch it swaps, then compares every known word of the host half with RAM contents computed from the address. If the shadow write were misaligned by the read latency, every compared word would be off by one address. If an unselected section were cleared, stale words that should survive would mismatch. The bench also sends commands while busy is set, and a combined swap-plus-fetch. A design that honoured the command during busy would leave the wrong buffer number visible to the host. A design that fetched before swapping would overwrite the half that the host was about to see.

// File: rtl/obuf_pkg.sv
package obuf_pkg;

  typedef enum logic {
    REG_SECT = 1'b0,
    REG_CMD  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic dat;
    logic hdr;
  } sect_t;

  localparam int CMD_SWAP_BIT  = 8;
  localparam int CMD_FETCH_BIT = 9;
  localparam int CMD_BUSY_BIT  = 15;
  localparam int CMD_HOST_LSB  = 16;
  localparam int SECT_HDR_BIT  = 0;
  localparam int SECT_DAT_BIT  = 1;
  localparam int SECT_HOST_LSB = 16;

endpackage

// File: rtl/obuf_rst_sync.sv
module obuf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/obuf_regs.sv
module obuf_regs
  import obuf_pkg::*;
#(
  parameter int BN_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_we,
  input  logic            cpu_addr,
  input  logic [31:0]     cpu_wdata,
  input  logic            busy,
  input  logic [BN_W-1:0] host_num,
  input  sect_t           host_sect,
  output logic [BN_W-1:0] req_num,
  output sect_t           shd_sect,
  output logic            fetch_go,
  output logic            swap_go,
  output logic [31:0]     cpu_rdata
);
  reg_sel_e        sel;
  logic            wr_cmd, wr_sect;
  logic [BN_W-1:0] tgt_q, tgt_n;
  sect_t           sect_q, sect_n;
  logic            unused_wdata;

  assign sel          = reg_sel_e'(cpu_addr);
  assign unused_wdata = ^cpu_wdata;

  // next-state
  always_comb begin
    wr_cmd  = cpu_we && (sel == REG_CMD);
    wr_sect = cpu_we && (sel == REG_SECT);
    tgt_n   = wr_cmd ? cpu_wdata[BN_W-1:0] : tgt_q;
    sect_n  = sect_q;
    if (wr_sect) begin
      sect_n.hdr = cpu_wdata[SECT_HDR_BIT];
      sect_n.dat = cpu_wdata[SECT_DAT_BIT];
    end
    fetch_go = wr_cmd && cpu_wdata[CMD_FETCH_BIT] && !busy;
    swap_go  = wr_cmd && cpu_wdata[CMD_SWAP_BIT]  && !busy;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      sect_q <= '0;
    end else begin
      if (wr_cmd)  tgt_q  <= tgt_n;
      if (wr_sect) sect_q <= sect_n;
    end
  end

  assign req_num  = tgt_n;
  assign shd_sect = sect_q;

  always_comb begin
    cpu_rdata = '0;
    case (sel)
      REG_CMD: begin
        cpu_rdata[BN_W-1:0]                = tgt_q;
        cpu_rdata[CMD_BUSY_BIT]            = busy;
        cpu_rdata[CMD_HOST_LSB +: BN_W]    = host_num;
      end
      default: begin
        cpu_rdata[SECT_HDR_BIT]            = sect_q.hdr;
        cpu_rdata[SECT_DAT_BIT]            = sect_q.dat;
        cpu_rdata[SECT_HOST_LSB]           = host_sect.hdr;
        cpu_rdata[SECT_HOST_LSB+1]         = host_sect.dat;
      end
    endcase
  end
endmodule

// File: rtl/obuf_seq.sv
module obuf_seq
  import obuf_pkg::*;
#(
  parameter int BN_W      = 7,
  parameter int HDR_WORDS = 2,
  parameter int SLOT      = 66,
  parameter int OFF_W     = 7,
  parameter int AW        = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             half_in,
  input  logic [BN_W-1:0]  num_in,
  input  sect_t            sect_in,
  output logic             ram_en,
  output logic [AW-1:0]    ram_addr,
  output logic             wr_en,
  output logic             wr_half,
  output logic [OFF_W-1:0] wr_off,
  output logic             busy
);
  localparam logic [OFF_W-1:0] HDR_FIRST = '0;
  localparam logic [OFF_W-1:0] HDR_LAST  = OFF_W'(HDR_WORDS - 1);
  localparam logic [OFF_W-1:0] DAT_FIRST = OFF_W'(HDR_WORDS);
  localparam logic [OFF_W-1:0] DAT_LAST  = OFF_W'(SLOT - 1);
  localparam logic [AW-1:0]    SLOT_A    = AW'(SLOT);

  logic             iss_q, iss_n;
  logic [OFF_W-1:0] off_q, off_n;
  logic [OFF_W-1:0] last_q, last_n;
  logic [BN_W-1:0]  num_q;
  logic             half_q;
  logic             wv_q, wv_n;
  logic [OFF_W-1:0] woff_q, woff_n;
  logic             start;

  // next-state
  always_comb begin
    start  = go && (sect_in.hdr || sect_in.dat);
    iss_n  = iss_q;
    off_n  = off_q;
    last_n = last_q;
    if (start) begin
      iss_n  = 1'b1;
      off_n  = sect_in.hdr ? HDR_FIRST : DAT_FIRST;
      last_n = sect_in.dat ? DAT_LAST  : HDR_LAST;
    end else if (iss_q) begin
      if (off_q == last_q) iss_n = 1'b0;
      else                 off_n = off_q + OFF_W'(1);
    end
    wv_n   = iss_q;
    woff_n = off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q  <= 1'b0;
      off_q  <= '0;
      last_q <= '0;
      num_q  <= '0;
      half_q <= 1'b0;
      wv_q   <= 1'b0;
      woff_q <= '0;
    end else begin
      iss_q  <= iss_n;
      off_q  <= off_n;
      last_q <= last_n;
      wv_q   <= wv_n;
      woff_q <= woff_n;
      if (start) begin
        num_q  <= num_in;
        half_q <= half_in;
      end
    end
  end

  assign ram_en   = iss_q;
  assign ram_addr = AW'(num_q) * SLOT_A + AW'(off_q);
  assign wr_en    = wv_q;
  assign wr_half  = half_q;
  assign wr_off   = woff_q;
  assign busy     = iss_q | wv_q;
endmodule

// File: rtl/obuf_store.sv
module obuf_store #(
  parameter int SLOT   = 66,
  parameter int OFF_W  = 7,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_half,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_half,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [2][SLOT];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_half][wr_off] <= wr_data;
  end

  always_comb begin
    if (rd_idx < OFF_W'(SLOT)) rd_data = mem[rd_half][rd_idx];
    else                       rd_data = '0;
  end
endmodule

// File: rtl/obuf_ctrl.sv
module obuf_ctrl
  import obuf_pkg::*;
#(
  parameter int BN_W       = 7,
  parameter int HDR_WORDS  = 2,
  parameter int DATA_WORDS = 64,
  parameter int WORD_W     = 32,
  localparam int SLOT      = HDR_WORDS + DATA_WORDS,
  localparam int OFF_W     = $clog2(SLOT),
  localparam int AW        = $clog2((2 ** BN_W) * SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic              cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              ram_en,
  output logic [AW-1:0]     ram_addr,
  input  logic [WORD_W-1:0] ram_rdata,
  input  logic [OFF_W-1:0]  host_idx,
  output logic [WORD_W-1:0] host_rdata
);
  logic             rst_n_s;
  logic [BN_W-1:0]  req_num;
  sect_t            shd_sect;
  logic             fetch_go, swap_go;
  logic             busy;
  logic             host_sel;
  logic             shd_next;
  logic [BN_W-1:0]  tag_num  [2];
  sect_t            tag_sect [2];
  logic [BN_W-1:0]  host_num;
  sect_t            host_sect;
  logic             wr_en, wr_half;
  logic [OFF_W-1:0] wr_off;

  obuf_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  obuf_regs #(.BN_W(BN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .busy      (busy),
    .host_num  (host_num),
    .host_sect (host_sect),
    .req_num   (req_num),
    .shd_sect  (shd_sect),
    .fetch_go  (fetch_go),
    .swap_go   (swap_go),
    .cpu_rdata (cpu_rdata)
  );

  // swap is applied before a fetch in the same write picks its half
  assign shd_next = ~(host_sel ^ swap_go);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     host_sel <= 1'b0;
    else if (swap_go) host_sel <= ~host_sel;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic            load;
    logic [BN_W-1:0] num_q;
    sect_t           sect_q;

    assign load = fetch_go && (shd_next == 1'(h));

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        num_q  <= '0;
        sect_q <= '0;
      end else if (load) begin
        num_q  <= req_num;
        sect_q <= shd_sect;
      end
    end

    assign tag_num[h]  = num_q;
    assign tag_sect[h] = sect_q;
  end

  assign host_num  = tag_num[host_sel];
  assign host_sect = tag_sect[host_sel];

  obuf_seq #(
    .BN_W(BN_W), .HDR_WORDS(HDR_WORDS), .SLOT(SLOT), .OFF_W(OFF_W), .AW(AW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .go       (fetch_go),
    .half_in  (shd_next),
    .num_in   (req_num),
    .sect_in  (shd_sect),
    .ram_en   (ram_en),
    .ram_addr (ram_addr),
    .wr_en    (wr_en),
    .wr_half  (wr_half),
    .wr_off   (wr_off),
    .busy     (busy)
  );

  obuf_store #(.SLOT(SLOT), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_half (wr_half),
    .wr_off  (wr_off),
    .wr_data (ram_rdata),
    .rd_half (host_sel),
    .rd_idx  (host_idx),
    .rd_data (host_rdata)
  );
endmodule

// File: rtl/obuf_ctrl_chk.sv
module obuf_ctrl_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ram_en,
  input logic [AW-1:0] ram_addr,
  input logic          host_sel
);
  AST_RAM_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && $past(ram_en)) |-> (ram_addr == $past(ram_addr) + AW'(1))); // R2

  AST_RAM_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> busy); // R3

  AST_BUSY_TAIL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ram_en) |=> !busy); // R3

  AST_BUSY_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ram_en); // R3

  AST_NO_SWAP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(host_sel)); // R7
endmodule

bind obuf_ctrl obuf_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_obuf_ctrl.sv
`timescale 1ns/1ps
module sim_obuf_ctrl;
  localparam int BN_W  = 7;
  localparam int HDR   = 2;
  localparam int DAT   = 64;
  localparam int SLOT  = HDR + DAT;
  localparam int OFF_W = $clog2(SLOT);
  localparam int AW    = $clog2((2 ** BN_W) * SLOT);

  logic              clk, rst_n, cpu_we, cpu_addr;
  logic [31:0]       cpu_wdata, cpu_rdata;
  logic              ram_en;
  logic [AW-1:0]     ram_addr;
  logic [31:0]       ram_rdata;
  logic [OFF_W-1:0]  host_idx;
  logic [31:0]       host_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] exp_mem [2][SLOT];
  bit          exp_vld [2][SLOT];
  int          exp_num [2];
  bit [1:0]    exp_sel [2];
  int          m_host = 0;

  obuf_ctrl u0 (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [31:0] ramf(int a);
    return (32'(a) * 32'h0001_0003) ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) if (ram_en) ram_rdata <= ramf(int'(ram_addr));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic a, logic [31:0] d);
    @(negedge clk);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic rd_reg(logic a, output logic [31:0] d);
    cpu_addr = a; #1; d = cpu_rdata;
  endtask

  task automatic wait_busy(output int cnt);
    logic [31:0] r;
    cnt = 0;
    rd_reg(1, r);
    while (r[15] && cnt < 500) begin
      cnt++;
      @(negedge clk);
      rd_reg(1, r);
    end
  endtask

  task automatic model_fill(int num, bit [1:0] sel);
    int sh = 1 - m_host;
    exp_num[sh] = num;
    exp_sel[sh] = sel;
    for (int o = 0; o < SLOT; o++)
      if ((o < HDR && sel[0]) || (o >= HDR && sel[1])) begin
        exp_mem[sh][o] = ramf(num * SLOT + o);
        exp_vld[sh][o] = 1;
      end
  endtask

  task automatic check_host(string req);
    logic [31:0] r;
    rd_reg(1, r);
    chk(req, "host number", 32'(r[22:16]), 32'(exp_num[m_host]));
    rd_reg(0, r);
    chk(req, "host flags", 32'(r[17:16]), 32'(exp_sel[m_host]));
    for (int o = 0; o < SLOT; o++)
      if (exp_vld[m_host][o]) begin
        host_idx = OFF_W'(o); #1;
        chk(req, "host word", host_rdata, exp_mem[m_host][o]);
      end
  endtask

  task automatic do_fetch(int num, bit [1:0] sel);
    logic [31:0] r;
    int cnt, words, expc;
    wr_reg(0, 32'(sel));
    wr_reg(1, 32'(num) | 32'h200);
    model_fill(num, sel);
    rd_reg(1, r);
    chk("R8", "command bits", 32'(r[9:8]), 32'd0);
    chk("R1", "target field", 32'(r[6:0]), 32'(num));
    wait_busy(cnt);
    words = (sel[0] ? HDR : 0) + (sel[1] ? DAT : 0);
    expc  = (words == 0) ? 0 : words + 1;
    chk("R3", "busy cycles", 32'(cnt), 32'(expc));
  endtask

  task automatic do_swap(int num);
    wr_reg(1, 32'(num) | 32'h100);
    m_host = 1 - m_host;
  endtask

  initial begin
    automatic logic [31:0] r;
    automatic int cnt;
    cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; host_idx = 0; rst_n = 0;
    for (int h = 0; h < 2; h++) begin
      exp_num[h] = 0; exp_sel[h] = 0;
      for (int o = 0; o < SLOT; o++) exp_vld[h][o] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    rd_reg(1, r); chk("R9", "command reg after reset", r, 32'd0);
    rd_reg(0, r); chk("R9", "select reg after reset", r, 32'd0);

    // R1 plain register access
    wr_reg(0, 32'hFFFF_FFFF);
    rd_reg(0, r); chk("R1", "select reg readback", r, 32'h0000_0003);
    wr_reg(1, 32'h0000_0055);
    rd_reg(1, r); chk("R1", "command reg readback", r, 32'h0000_0055);

    // R2 R4 R5: sweep every buffer number and all section patterns
    for (int n = 0; n < 128; n++) begin
      do_fetch(n, 2'(n % 4));
      do_swap(n);
      check_host("R2/R4/R5");
    end

    // R7: commands during busy are dropped, target number still stored
    wr_reg(0, 32'h3);
    wr_reg(1, 32'd5 | 32'h200);
    model_fill(5, 2'b11);
    wr_reg(1, 32'd9 | 32'h300);
    rd_reg(1, r);
    chk("R7", "busy during transfer", 32'(r[15]), 32'd1);
    chk("R7", "target stored while busy", 32'(r[6:0]), 32'd9);
    chk("R7", "host unchanged while busy", 32'(r[22:16]), 32'(exp_num[m_host]));
    wait_busy(cnt);
    do_swap(9);
    check_host("R7");

    // R6: swap and fetch in one write
    wr_reg(0, 32'h3);
    wr_reg(1, 32'd33 | 32'h300);
    m_host = 1 - m_host;
    model_fill(33, 2'b11);
    rd_reg(1, r);
    chk("R6", "host after combined write", 32'(r[22:16]), 32'(exp_num[m_host]));
    wait_busy(cnt);
    chk("R6", "busy cycles combined", 32'(cnt), 32'(SLOT + 1));
    check_host("R6");
    do_swap(0);
    check_host("R6");
    do_swap(0);
    check_host("R6");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule